// File: doc/BRIEF.md
# Port Operating Mode Controller

This block keeps the operating mode of several switch agents, which may be line ports or host gateways, and controls a clock enable for each one. Software writes a requested mode into an agent's command register. The change then runs for a fixed number of cycles. The agent's status register keeps showing the previous mode, with a change-in-progress flag set, until the change completes. When a change into the disable mode completes, the controller also removes that agent's clock enable.

A request made while the agent's clock is gated waits in a pending state and does not advance until the clock is enabled again. The block also holds the shared clock-enable and clock-disable registers and a software reset bit. Each agent has a one-shot RAM initialisation sequencer: software writes a go bit, the sequencer sweeps the RAM depth, and it then raises a ready bit. All registers are reached through a simple register bus with read and write strobes. A read returns its data one cycle after the read strobe.

Register map (byte addresses; agent `i` sits at base 0x40 + 16*i):

- 0x00 soft reset: bit 0.
- 0x04 clock enable: write-1-to-set. Bit 16 is the global enable; bits 0..N-1 are the agent enables.
- 0x08 clock disable: write-1-to-clear for the agent enables. Reads as zero.
- agent +0x0 command: bits [1:0] hold the requested mode.
- agent +0x4 status: bits [1:0] hold the current mode; bit 2 is the change-in-progress flag.
- agent +0x8 RAM init: write bit 0 to start. On read, bit 0 is running and bit 1 is ready.

Top module: `agent_mode_ctrl`

## Requirements
- R1: After reset, every agent's status reads 0: mode 0 (reset) with no change in progress. The clock-enable register reads 0, and the `agent_clk_en` and `agent_mode` outputs are all zero.
- R2: The mode encoding is 0 reset, 1 disable, 2 config, 3 operation. After a command write to an agent whose clock is on, status bits [1:0] keep the old mode and status bit 2 reads 1 for TRANS_CYCLES clock edges. From then on, bits [1:0] show the new mode and bit 2 reads 0.
- R3: Writing 1s to the clock-enable register at 0x04 sets those bits (bit 16 global, bit i agent i) and leaves the other bits unchanged. `agent_clk_en[i]` equals the global bit ANDed with agent bit i.
- R4: Writing a 1 to bit i of the clock-disable register at 0x08 clears agent enable bit i and leaves the other bits unchanged. A read of 0x08 returns 0.
- R5: When a change into mode 1 (disable) completes, that agent's clock-enable bit is cleared in the same cycle.
- R6: A command issued while the agent's clock is off leaves status at the old mode with bit 2 set, for any length of time. Once the clock is enabled, the change completes.
- R7: Writing bit 0 of an agent's RAM-init register starts a sweep. The read value is 1 (running) until RAM_DEPTH edges after the write edge, and 2 (ready) after that.
- R8: Writing the go bit again clears ready and restarts the sweep.
- R9: While soft-reset bit 0 at 0x00 is 1, every agent is held in mode 0 and command writes are ignored. After the bit is written back to 0, the agents stay in mode 0.
- R10: A command to one agent does not change any other agent's status.
- R11: A command written while a change is still in progress restarts the change toward the new mode, with the full TRANS_CYCLES delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| agent_clk_en | output | NUM_AGENTS | Effective per-agent clock enable |
| agent_mode | output | 2*NUM_AGENTS | Current mode of each agent, 2 bits per agent |

## Verification
The hardest state to reach is a command held in the pending state. Reaching it needs an agent whose clock was first removed, either by the automatic gating at the end of a change into disable or by the clock-disable register, and only then given a command. The stimulus therefore drives agent 0 into disable to observe the automatic gating. It clears agent 1 through the disable register, issues a command, idles for tens of cycles, and only then re-enables the clock. The exact cycle boundaries of a mode change and of the RAM sweep are checked by reads placed one cycle before and one cycle after the expected completion edge.

// File: rtl/agent_mode_pkg.sv
package agent_mode_pkg;

    localparam int REG_AW        = 8;
    localparam int REG_DW        = 32;
    localparam int GLOBAL_EN_BIT = 16;
    localparam int AGENT_BASE    = 8'h40;

    typedef enum logic [1:0] {
        MODE_RESET   = 2'd0,
        MODE_DISABLE = 2'd1,
        MODE_CONFIG  = 2'd2,
        MODE_OPERATE = 2'd3
    } op_mode_e;

    typedef enum logic [1:0] {
        XS_IDLE    = 2'd0,
        XS_PENDING = 2'd1,
        XS_BUSY    = 2'd2
    } xfer_state_e;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_SWRST,
        SEL_CLKEN,
        SEL_CLKDIS,
        SEL_CMD,
        SEL_STAT,
        SEL_RAMINIT
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [3:0] agent;
    } reg_hit_t;

    function automatic reg_hit_t decode_addr(input logic [REG_AW-1:0] a, input int n_agents);
        reg_hit_t        h;
        logic [REG_AW-1:0] off;
        h.sel   = SEL_NONE;
        h.agent = '0;
        off     = a - REG_AW'(AGENT_BASE);
        if (a == 8'h00)      h.sel = SEL_SWRST;
        else if (a == 8'h04) h.sel = SEL_CLKEN;
        else if (a == 8'h08) h.sel = SEL_CLKDIS;
        else if (a >= REG_AW'(AGENT_BASE) && a[1:0] == 2'b00) begin
            h.agent = off[7:4];
            if (int'(off[7:4]) < n_agents) begin
                case (a[3:2])
                    2'd0:    h.sel = SEL_CMD;
                    2'd1:    h.sel = SEL_STAT;
                    2'd2:    h.sel = SEL_RAMINIT;
                    default: h.sel = SEL_NONE;
                endcase
            end
        end
        return h;
    endfunction

endpackage

// File: rtl/agent_mode_fsm.sv
module agent_mode_fsm
    import agent_mode_pkg::*;
#(
    parameter int TRANS_CYCLES = 4
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     force_rst,
    input  logic     cmd_we,
    input  op_mode_e cmd_mode,
    input  logic     clk_on,
    output op_mode_e cur_mode,
    output logic     changing,
    output logic     enter_disable
);
    localparam int CW = (TRANS_CYCLES > 1) ? $clog2(TRANS_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(TRANS_CYCLES - 1);

    xfer_state_e   state;
    op_mode_e      tgt_mode;
    logic [CW-1:0] cnt;

    assign changing      = (state != XS_IDLE);
    assign enter_disable = (state == XS_BUSY) && clk_on && (cnt == '0) &&
                           (tgt_mode == MODE_DISABLE) && !cmd_we && !force_rst;

    always_ff @(posedge clk) begin
        if (rst || force_rst) begin
            state    <= XS_IDLE;
            cur_mode <= MODE_RESET;
            tgt_mode <= MODE_RESET;
            cnt      <= '0;
        end else if (cmd_we) begin
            tgt_mode <= cmd_mode;
            cnt      <= CNT_LOAD;
            state    <= clk_on ? XS_BUSY : XS_PENDING;
        end else begin
            case (state)
                XS_PENDING: if (clk_on) state <= XS_BUSY;
                XS_BUSY: begin
                    if (clk_on) begin
                        if (cnt == '0) begin
                            cur_mode <= tgt_mode;
                            state    <= XS_IDLE;
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                end
                default: state <= XS_IDLE;
            endcase
        end
    end

    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (rst)
        (state == XS_IDLE && !cmd_we && !force_rst) |=> $stable(cur_mode));

    assert_pending_hold_R6: assert property (@(posedge clk) disable iff (rst)
        (state == XS_PENDING && !clk_on && !cmd_we && !force_rst)
        |=> (state == XS_PENDING && $stable(cur_mode)));

    assert_swreset_hold_R9: assert property (@(posedge clk) disable iff (rst)
        force_rst |=> (cur_mode == MODE_RESET && !changing));

    assert_restart_busy_R11: assert property (@(posedge clk) disable iff (rst)
        (cmd_we && !force_rst) |=> changing);

endmodule

// File: rtl/ram_init_seq.sv
module ram_init_seq #(
    parameter int RAM_DEPTH = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic go_we,
    output logic running,
    output logic ready
);
    localparam int AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;
    localparam logic [AW-1:0] LAST = AW'(RAM_DEPTH - 1);

    logic [AW-1:0] sweep_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            running    <= 1'b0;
            ready      <= 1'b0;
            sweep_addr <= '0;
        end else if (go_we) begin
            running    <= 1'b1;
            ready      <= 1'b0;
            sweep_addr <= '0;
        end else if (running) begin
            if (sweep_addr == LAST) begin
                running <= 1'b0;
                ready   <= 1'b1;
            end else begin
                sweep_addr <= sweep_addr + 1'b1;
            end
        end
    end

    assert_go_clears_ready_R8: assert property (@(posedge clk) disable iff (rst)
        go_we |=> (!ready && running));

    assert_sweep_done_R7: assert property (@(posedge clk) disable iff (rst)
        (running && !go_we && sweep_addr == LAST) |=> (ready && !running));

endmodule

// File: rtl/clock_enable_regs.sv
module clock_enable_regs
    import agent_mode_pkg::*;
#(
    parameter int NUM_AGENTS = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  set_we,
    input  logic                  clr_we,
    input  logic [NUM_AGENTS-1:0] agent_bits,
    input  logic                  global_bit,
    input  logic [NUM_AGENTS-1:0] disable_req,
    output logic                  global_en,
    output logic [NUM_AGENTS-1:0] agent_en,
    output logic [NUM_AGENTS-1:0] gate
);
    logic [NUM_AGENTS-1:0] set_mask, clr_mask;

    assign set_mask = set_we ? agent_bits : '0;
    assign clr_mask = (clr_we ? agent_bits : '0) | disable_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            global_en <= 1'b0;
            agent_en  <= '0;
        end else begin
            global_en <= global_en | (set_we & global_bit);
            agent_en  <= (agent_en | set_mask) & ~clr_mask;
        end
    end

    genvar gi;
    generate
        for (gi = 0; gi < NUM_AGENTS; gi++) begin : g_gate
            assign gate[gi] = global_en & agent_en[gi];
        end
    endgenerate

    assert_auto_gate_R5: assert property (@(posedge clk) disable iff (rst)
        (|disable_req) |=> ((agent_en & $past(disable_req)) == '0));

    assert_clk_clear_R4: assert property (@(posedge clk) disable iff (rst)
        clr_we |=> ((agent_en & $past(agent_bits)) == '0));

    assert_clk_set_R3: assert property (@(posedge clk) disable iff (rst)
        (set_we && !clr_we && disable_req == '0)
        |=> ((agent_en & $past(agent_bits)) == $past(agent_bits)));

endmodule

// File: rtl/agent_mode_ctrl.sv
module agent_mode_ctrl
    import agent_mode_pkg::*;
#(
    parameter int NUM_AGENTS   = 4,
    parameter int TRANS_CYCLES = 4,
    parameter int RAM_DEPTH    = 16
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    wr_en,
    input  logic                    rd_en,
    input  logic [7:0]              addr,
    input  logic [31:0]             wdata,
    output logic [31:0]             rdata,
    output logic [NUM_AGENTS-1:0]   agent_clk_en,
    output logic [2*NUM_AGENTS-1:0] agent_mode
);
    localparam int AIW = (NUM_AGENTS > 1) ? $clog2(NUM_AGENTS) : 1;

    reg_hit_t              hit;
    logic [AIW-1:0]        idx;
    logic                  swrst_q;
    logic                  global_en;
    logic [NUM_AGENTS-1:0] agent_en;
    logic [NUM_AGENTS-1:0] cmd_we, go_we, changing, dis_req, running, ready;
    op_mode_e              mode_arr [NUM_AGENTS];
    logic                  unused_wdata;

    assign hit          = decode_addr(addr, NUM_AGENTS);
    assign idx          = hit.agent[AIW-1:0];
    assign unused_wdata = ^{wdata[31:GLOBAL_EN_BIT+1], wdata[GLOBAL_EN_BIT-1:0]};

    always_ff @(posedge clk) begin
        if (rst)                              swrst_q <= 1'b0;
        else if (wr_en && hit.sel == SEL_SWRST) swrst_q <= wdata[0];
    end

    clock_enable_regs #(.NUM_AGENTS(NUM_AGENTS)) u_clk (
        .clk         (clk),
        .rst         (rst),
        .set_we      (wr_en && hit.sel == SEL_CLKEN),
        .clr_we      (wr_en && hit.sel == SEL_CLKDIS),
        .agent_bits  (wdata[NUM_AGENTS-1:0]),
        .global_bit  (wdata[GLOBAL_EN_BIT]),
        .disable_req (dis_req),
        .global_en   (global_en),
        .agent_en    (agent_en),
        .gate        (agent_clk_en)
    );

    genvar gi;
    generate
        for (gi = 0; gi < NUM_AGENTS; gi++) begin : g_agent
            assign cmd_we[gi] = wr_en && hit.sel == SEL_CMD && hit.agent == 4'(gi);
            assign go_we[gi]  = wr_en && hit.sel == SEL_RAMINIT && hit.agent == 4'(gi) && wdata[0];

            agent_mode_fsm #(.TRANS_CYCLES(TRANS_CYCLES)) u_fsm (
                .clk           (clk),
                .rst           (rst),
                .force_rst     (swrst_q),
                .cmd_we        (cmd_we[gi]),
                .cmd_mode      (op_mode_e'(wdata[1:0])),
                .clk_on        (agent_clk_en[gi]),
                .cur_mode      (mode_arr[gi]),
                .changing      (changing[gi]),
                .enter_disable (dis_req[gi])
            );

            ram_init_seq #(.RAM_DEPTH(RAM_DEPTH)) u_ram (
                .clk     (clk),
                .rst     (rst),
                .go_we   (go_we[gi]),
                .running (running[gi]),
                .ready   (ready[gi])
            );

            assign agent_mode[2*gi +: 2] = mode_arr[gi];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= '0;
            case (hit.sel)
                SEL_SWRST: rdata[0] <= swrst_q;
                SEL_CLKEN: begin
                    rdata[GLOBAL_EN_BIT]  <= global_en;
                    rdata[NUM_AGENTS-1:0] <= agent_en;
                end
                SEL_STAT: begin
                    rdata[1:0] <= mode_arr[idx];
                    rdata[2]   <= changing[idx];
                end
                SEL_RAMINIT: begin
                    rdata[0] <= running[idx];
                    rdata[1] <= ready[idx];
                end
                default: rdata <= '0;
            endcase
        end
    end

    assert_clkdis_reads_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && hit.sel == SEL_CLKDIS) |=> (rdata == '0));

    assert_gate_needs_global_R3: assert property (@(posedge clk) disable iff (rst)
        !global_en |-> (agent_clk_en == '0));

endmodule

// File: tb/tb_agent_mode_ctrl.sv
`timescale 1ns/1ps
module tb_agent_mode_ctrl;
    localparam int NA = 4;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en, rd_en;
    logic [7:0]    addr;
    logic [31:0]   wdata;
    logic [31:0]   rdata;
    logic [NA-1:0] agent_clk_en;
    logic [2*NA-1:0] agent_mode;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #2.5 clk = ~clk;

    agent_mode_ctrl #(.NUM_AGENTS(NA), .TRANS_CYCLES(4), .RAM_DEPTH(16)) dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .agent_clk_en(agent_clk_en), .agent_mode(agent_mode)
    );

    typedef struct packed {
        logic [1:0]  op;   // 0 write, 1 read-check, 2 idle (data = cycles)
        logic [7:0]  addr;
        logic [31:0] data;
        logic [31:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VT [NV] = '{
        '{2'd1, 8'h04, 32'h0,     32'h0,     8'd1},  // R1
        '{2'd1, 8'h44, 32'h0,     32'h0,     8'd1},  // R1
        '{2'd1, 8'h54, 32'h0,     32'h0,     8'd1},  // R1
        '{2'd0, 8'h04, 32'h10001, 32'h0,     8'd3},
        '{2'd1, 8'h04, 32'h0,     32'h10001, 8'd3},  // R3
        '{2'd0, 8'h40, 32'h2,     32'h0,     8'd2},
        '{2'd1, 8'h44, 32'h0,     32'h4,     8'd2},  // R2 in progress
        '{2'd2, 8'h00, 32'd4,     32'h0,     8'd2},
        '{2'd1, 8'h44, 32'h0,     32'h2,     8'd2},  // R2 config
        '{2'd0, 8'h40, 32'h3,     32'h0,     8'd2},
        '{2'd2, 8'h00, 32'd6,     32'h0,     8'd2},
        '{2'd1, 8'h44, 32'h0,     32'h3,     8'd2},  // R2 operation
        '{2'd0, 8'h40, 32'h1,     32'h0,     8'd5},
        '{2'd2, 8'h00, 32'd6,     32'h0,     8'd5},
        '{2'd1, 8'h44, 32'h0,     32'h1,     8'd5},  // R5 mode
        '{2'd1, 8'h04, 32'h0,     32'h10000, 8'd5}   // R5 clock bit gone
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // All tasks start and end at a negative edge.
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        rd_en = 1'b1; addr = a;
        @(posedge clk); @(negedge clk);
        rd_en = 1'b0;
        check(req, rdata, exp);
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: port values after reset
        check("R1 clk_en port", 32'(agent_clk_en), 32'h0);
        check("R1 mode port", 32'(agent_mode), 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VT[i].op)
                2'd0: wr(VT[i].addr, VT[i].data);
                2'd1: rd_chk(VT[i].addr, VT[i].exp, $sformatf("R%0d vec%0d", VT[i].req, i));
                default: idle(int'(VT[i].data));
            endcase
        end

        // R3: set agents 1 and 2, agent0 stays off after auto gating
        wr(8'h04, 32'h6);
        rd_chk(8'h04, 32'h10006, "R3 set agents 1,2");
        check("R3 gate port", 32'(agent_clk_en), 32'h6);
        check("R5 mode port agent0", 32'(agent_mode[1:0]), 32'h1);

        // R4: clear agent 1 only
        wr(8'h08, 32'h2);
        rd_chk(8'h04, 32'h10004, "R4 clear agent1");
        rd_chk(8'h08, 32'h0, "R4 disable reg reads zero");
        check("R4 gate port", 32'(agent_clk_en), 32'h4);

        // R6: command to gated agent 1 stays pending
        wr(8'h50, 32'h2);
        idle(40);
        rd_chk(8'h54, 32'h4, "R6 pending while gated");
        wr(8'h04, 32'h2);
        idle(8);
        rd_chk(8'h54, 32'h2, "R6 completes after enable");

        // R11: restart while in progress on agent 2
        wr(8'h60, 32'h2);
        idle(2);
        wr(8'h60, 32'h3);
        idle(2);
        rd_chk(8'h64, 32'h4, "R11 still old mode after restart");
        idle(6);
        rd_chk(8'h64, 32'h3, "R11 new target reached");

        // R10: independence
        rd_chk(8'h74, 32'h0, "R10 agent3 untouched");
        rd_chk(8'h54, 32'h2, "R10 agent1 unchanged");

        // R7: RAM init boundary on agent 0
        wr(8'h48, 32'h1);
        idle(15);
        rd_chk(8'h48, 32'h1, "R7 running at last sweep edge");
        rd_chk(8'h48, 32'h2, "R7 ready after sweep");

        // R8: go again clears ready
        wr(8'h48, 32'h1);
        rd_chk(8'h48, 32'h1, "R8 ready cleared on restart");

        // R9: soft reset
        wr(8'h00, 32'h1);
        idle(1);
        rd_chk(8'h64, 32'h0, "R9 agent2 forced to reset");
        wr(8'h60, 32'h2);
        idle(6);
        rd_chk(8'h64, 32'h0, "R9 command ignored in reset");
        wr(8'h00, 32'h0);
        idle(6);
        rd_chk(8'h54, 32'h0, "R9 agent1 stays in reset");
        check("R9 mode port", 32'(agent_mode), 32'h0);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end

endmodule